// File: doc/BRIEF.md
# Dual Event Counter with Shared Context Gating

This block keeps two 32-bit event counters that share one control register. Each cycle it receives a 64-wide vector of event pulses and a code for the current privilege context (user, supervisor, hypervisor or none). Each counter has its own 6-bit select field that picks one bit of the pulse vector. The three context enable bits are common to both counters, so neither counter can be started or stopped alone. The only way to halt counting is to clear all three enable bits.

The counters are read and written as one 64-bit word: counter 0 is the low half and counter 1 is the high half. A single access always moves both halves in the same cycle. When a counter wraps from all ones to zero, it sets a sticky overflow flag in the control register. Software clears that flag by writing 1 to it. An interrupt line reports each flag whose interrupt enable is set.

Pulse bit 0 is reserved for an input that fires when a dedicated no-operation encoding retires. Software points an unused counter at it so that the counter stays almost still.

Top module: `evt_pair_counter`

## Requirements
- R1: After reset, both counters read 0, the control register reads 0 and `irq` is 0.
- R2: A write to address 1 loads `bus_wdata[31:0]` into counter 0 and `bus_wdata[63:32]` into counter 1 in the same cycle. A read of address 1 returns {counter 1, counter 0}.
- R3: The control register sits at address 0. Its select field for counter 0 is in bits [5:0] and its select field for counter 1 is in bits [13:8]. On each clock edge where the selected `evt_pulse` bit is 1 and the current context is enabled, a counter advances by exactly 1.
- R4: `ctx` uses this encoding: 0 is user, 1 is supervisor, 2 is hypervisor and 3 is none. The matching enable bits are control bits 16, 17 and 18. Counting happens only when the enable bit for the current context is set, and that bit applies to both counters. Context code 3 never counts.
- R5: While control bits [18:16] are all 0, neither counter changes, whatever pulses arrive.
- R6: An increment that takes a counter from 0xFFFFFFFF to 0 sets a sticky overflow flag. The flag for counter 0 is control bit 24 and the flag for counter 1 is control bit 25.
- R7: A write to the control register clears each overflow flag whose bit in `bus_wdata` is 1. A flag whose bit is 0 is left unchanged. The other control fields take the written value.
- R8: `irq` is 1 exactly when (flag 0 AND bit 20) OR (flag 1 AND bit 21). Bits 20 and 21 are the overflow interrupt enables. `irq` follows the flags and enables in the same cycle, with no added register delay.
- R9: When a counter write and an increment fall in the same cycle, the counter takes the written value. The increment is dropped and no overflow is flagged.
- R10: Select code 0 picks `evt_pulse[0]`, the no-operation-retire event. While that code is selected, pulses on any other bit do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 selects the control register, 1 selects the counter pair |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 64 | Event pulses, one bit per event code |
| ctx | input | 2 | Current privilege context |
| irq | output | 1 | Overflow interrupt |

## Verification
A wrong count or a wrong gating decision appears in the counter word on the first read after the edge where it happens. Because both halves are read together, an error in the shared gate shows in both counters at once, while a wrong select shows in one half only. A lost or stuck overflow flag shows in control bits 24–25 and on `irq` in the same cycle it is read. The bench therefore checks the flags and `irq` right after each wrap, after each write-one-to-clear and after each interrupt-enable change.

// File: rtl/evtcnt_pkg.sv
// Shared constants for the dual event counter: register addresses,
// control field positions and the context encoding.
package evtcnt_pkg;

    // Register addresses on the one-bit register bus
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CNT  = 1'b1;

    // Control field positions (select fields are at most 8 bits wide)
    localparam int SEL0_LSB = 0;
    localparam int SEL1_LSB = 8;
    localparam int EN_LSB   = 16;
    localparam int OVIE_LSB = 20;
    localparam int OVF_LSB  = 24;
    localparam int SEL_STRIDE = SEL1_LSB - SEL0_LSB;

    // Privilege context encoding on the ctx input
    typedef enum logic [1:0] {
        CTX_USER = 2'd0,
        CTX_SUP  = 2'd1,
        CTX_HYP  = 2'd2,
        CTX_NONE = 2'd3
    } ctx_e;

endpackage

// File: rtl/evtcnt_gate.sv
// Context gate: decides whether counting is allowed in this cycle.
// Assumes the three enable bits are ordered user, supervisor, hypervisor.
// The result is shared by both counter lanes.
module evtcnt_gate
    import evtcnt_pkg::*;
(
    input  logic [1:0] ctx,
    input  logic [2:0] ctx_en,
    output logic       gate_open
);

    // Pick the enable bit that belongs to the current context
    always_comb begin
        case (ctx_e'(ctx))
            CTX_USER: gate_open = ctx_en[0];
            CTX_SUP:  gate_open = ctx_en[1];
            CTX_HYP:  gate_open = ctx_en[2];
            default:  gate_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/evtcnt_lane.sv
// One counter lane: selects an event bit, counts it while the gate is
// open, and flags a wrap from all ones to zero.
// Assumes a load from the bus overrides the increment in the same cycle.
module evtcnt_lane #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 6,
    localparam int EVT_N = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_pulse,
    input  logic [SEL_W-1:0] sel,
    input  logic             gate_open,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_hit
);

    logic inc;

    // Qualify the selected event with the shared context gate
    always_comb begin
        inc      = gate_open && evt_pulse[sel];
        wrap_hit = inc && !load && (cnt == {CNT_W{1'b1}});
    end

    // Counter register: a load wins over an increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (inc)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/evtcnt_ctrl.sv
// Shared control register: two event selects, three context enables,
// two overflow interrupt enables and two sticky overflow flags.
// Assumes a new wrap in the same cycle as a write-one-to-clear keeps
// the flag set.
module evtcnt_ctrl
    import evtcnt_pkg::*;
#(
    parameter int SEL_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [1:0]            wrap_hit,
    output logic [1:0][SEL_W-1:0] sel,
    output logic [2:0]            ctx_en,
    output logic [1:0]            ovie,
    output logic [1:0]            ovf,
    output logic [DATA_W-1:0]     rdata
);

    // Select, enable and interrupt-enable fields, replaced on each write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            ctx_en <= '0;
            ovie   <= '0;
        end else if (wr) begin
            for (int i = 0; i < 2; i++)
                sel[i] <= wdata[SEL0_LSB + i*SEL_STRIDE +: SEL_W];
            ctx_en <= wdata[EN_LSB +: 3];
            ovie   <= wdata[OVIE_LSB +: 2];
        end
    end

    // Sticky overflow flags: set on a wrap, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= '0;
        else
            for (int i = 0; i < 2; i++)
                if (wrap_hit[i])
                    ovf[i] <= 1'b1;
                else if (wr && wdata[OVF_LSB + i])
                    ovf[i] <= 1'b0;
    end

    // Assemble the readback word
    always_comb begin
        rdata = '0;
        for (int i = 0; i < 2; i++)
            rdata[SEL0_LSB + i*SEL_STRIDE +: SEL_W] = sel[i];
        rdata[EN_LSB +: 3]   = ctx_en;
        rdata[OVIE_LSB +: 2] = ovie;
        rdata[OVF_LSB +: 2]  = ovf;
    end

endmodule

// File: rtl/evt_pair_counter.sv
// Dual event counter top. Two lanes share one context gate and one
// control register. The counters are accessed as a single word
// {counter 1, counter 0}. Reads are combinational; writes act on the
// clock edge. The reset is synchronous and active low.
module evt_pair_counter
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 6,
    localparam int EVT_N  = 1 << SEL_W,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [1:0]        ctx,
    output logic              irq
);

    logic                  ctrl_wr;
    logic                  cnt_wr;
    logic                  gate_open;
    logic [1:0][SEL_W-1:0] sel;
    logic [2:0]            ctx_en;
    logic [1:0]            ovie;
    logic [1:0]            ovf_flags;
    logic [1:0]            wrap_hit;
    logic [DATA_W-1:0]     ctrl_rdata;
    logic [DATA_W-1:0]     cnt_all;

    // Decode the write strobe by address
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        cnt_wr  = bus_wr && (bus_addr == ADDR_CNT);
    end

    evtcnt_gate u_gate (
        .ctx       (ctx),
        .ctx_en    (ctx_en),
        .gate_open (gate_open)
    );

    evtcnt_ctrl #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (bus_wdata),
        .wrap_hit (wrap_hit),
        .sel      (sel),
        .ctx_en   (ctx_en),
        .ovie     (ovie),
        .ovf      (ovf_flags),
        .rdata    (ctrl_rdata)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        evtcnt_lane #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_pulse (evt_pulse),
            .sel       (sel[g]),
            .gate_open (gate_open),
            .load      (cnt_wr),
            .load_val  (bus_wdata[g*CNT_W +: CNT_W]),
            .cnt       (cnt_all[g*CNT_W +: CNT_W]),
            .wrap_hit  (wrap_hit[g])
        );
    end

    // Read multiplexer and interrupt output
    always_comb begin
        bus_rdata = (bus_addr == ADDR_CNT) ? cnt_all : ctrl_rdata;
        irq       = |(ovf_flags & ovie);
    end

endmodule

// Temporal checks on the dual event counter
module evt_pair_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_wr,
    input logic               ctrl_wr,
    input logic [2*CNT_W-1:0] wdata,
    input logic [2*CNT_W-1:0] cnt,
    input logic               gate_open,
    input logic [2:0]         ctx_en,
    input logic [1:0]         ovf
);

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wdata));

    // R3
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt[CNT_W-1:0] == $past(cnt[CNT_W-1:0]) ||
                     cnt[CNT_W-1:0] == $past(cnt[CNT_W-1:0]) + CNT_W'(1)));

    // R4
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !cnt_wr) |=> $stable(cnt));

    // R5
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_en == 3'b000) |-> !gate_open);

    // R6
    lo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt[CNT_W-1:0] == '1) ##1 (cnt[CNT_W-1:0] == '0) |-> ovf[0]);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !ctrl_wr) |=> ovf[0]);

endmodule

bind evt_pair_counter evt_pair_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr),
    .ctrl_wr   (ctrl_wr),
    .wdata     (bus_wdata),
    .cnt       (cnt_all),
    .gate_open (gate_open),
    .ctx_en    (ctx_en),
    .ovf       (ovf_flags)
);

// File: tb/evt_pair_counter_bench.sv
`timescale 1ns/1ps
module evt_pair_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] evt_pulse = '0;
    logic [1:0]  ctx = 2'd0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_pair_counter u_evt_pair_counter (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .ctx(ctx), .irq(irq)
    );

    function automatic logic [63:0] mk_ctrl(input logic [5:0] s0, input logic [5:0] s1,
                                            input logic [2:0] en, input logic [1:0] ie,
                                            input logic [1:0] w1c);
        logic [63:0] v = '0;
        v[5:0] = s0; v[13:8] = s1; v[18:16] = en; v[21:20] = ie; v[25:24] = w1c;
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [63:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [63:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse(input logic [63:0] v, input int n);
        @(negedge clk); evt_pulse = v;
        repeat (n) @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(1'b1, d); chk("R1 counters", d, 64'h0);
        rd(1'b0, d); chk("R1 control", d, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        pulse('1, 3);
        rd(1'b1, d); chk("R5 reset enables off", d, 64'h0);
    endtask

    task automatic t_basic();
        logic [63:0] d;
        ctx = 2'd0;
        wr(1'b0, mk_ctrl(6'd5, 6'd9, 3'b001, 2'b00, 2'b00));
        rd(1'b0, d); chk("R3 control readback", d, mk_ctrl(6'd5, 6'd9, 3'b001, 2'b00, 2'b00));
        wr(1'b1, 64'h0);
        pulse((64'h1 << 5) | (64'h1 << 9), 2);
        pulse(64'h1 << 9, 3);
        pulse(64'h1 << 6, 2);
        rd(1'b1, d); chk("R3 independent selects", d, {32'd5, 32'd2});
        wr(1'b1, {32'h1234_5678, 32'h9abc_def0});
        rd(1'b1, d); chk("R2 packed write", d, {32'h1234_5678, 32'h9abc_def0});
    endtask

    task automatic t_ctx();
        logic [63:0] d;
        wr(1'b0, mk_ctrl(6'd2, 6'd2, 3'b001, 2'b00, 2'b00));
        wr(1'b1, 64'h0);
        ctx = 2'd1; pulse(64'h4, 3);
        ctx = 2'd2; pulse(64'h4, 3);
        rd(1'b1, d); chk("R4 other contexts blocked", d, 64'h0);
        ctx = 2'd0; pulse(64'h4, 3);
        rd(1'b1, d); chk("R4 user counts", d, {32'd3, 32'd3});
        wr(1'b0, mk_ctrl(6'd2, 6'd2, 3'b110, 2'b00, 2'b00));
        ctx = 2'd0; pulse(64'h4, 2);
        ctx = 2'd2; pulse(64'h4, 2);
        rd(1'b1, d); chk("R4 hypervisor shared enable", d, {32'd5, 32'd5});
        wr(1'b0, mk_ctrl(6'd2, 6'd2, 3'b111, 2'b00, 2'b00));
        ctx = 2'd3; pulse('1, 4);
        rd(1'b1, d); chk("R4 context none", d, {32'd5, 32'd5});
        wr(1'b0, mk_ctrl(6'd2, 6'd2, 3'b000, 2'b00, 2'b00));
        ctx = 2'd1; pulse('1, 4);
        ctx = 2'd0; pulse('1, 4);
        rd(1'b1, d); chk("R5 all enables clear", d, {32'd5, 32'd5});
    endtask

    task automatic t_write_pri();
        logic [63:0] d;
        ctx = 2'd0;
        wr(1'b0, mk_ctrl(6'd7, 6'd7, 3'b001, 2'b00, 2'b00));
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = {32'hFFFF_FFFF, 32'h0000_0100};
        bus_wr = 1'b1; evt_pulse = 64'h80;
        @(negedge clk); bus_wr = 1'b0; evt_pulse = '0;
        rd(1'b1, d); chk("R9 write beats increment", d, {32'hFFFF_FFFF, 32'h0000_0100});
        rd(1'b0, d); chk("R9 no flag on load", d[25:24], 64'h0);
        pulse(64'h80, 1);
        rd(1'b1, d); chk("R9 counting resumes", d, {32'h0, 32'h0000_0101});
        rd(1'b0, d); chk("R6 high wrap flag", d[25:24], 64'h2);
        wr(1'b0, mk_ctrl(6'd7, 6'd7, 3'b001, 2'b00, 2'b10));
        rd(1'b0, d); chk("R7 clear high flag", d[25:24], 64'h0);
    endtask

    task automatic t_ovf();
        logic [63:0] d;
        ctx = 2'd0;
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b00, 2'b00));
        wr(1'b1, {32'h10, 32'hFFFF_FFFE});
        pulse(64'h8, 2);
        rd(1'b1, d); chk("R6 low wrap value", d, {32'h10, 32'h0});
        rd(1'b0, d); chk("R6 low flag", d[25:24], 64'h1);
        chk("R8 irq masked", {63'h0, irq}, 64'h0);
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b01, 2'b00));
        chk("R8 irq enabled", {63'h0, irq}, 64'h1);
        rd(1'b0, d); chk("R7 zero write keeps flag", d[25:24], 64'h1);
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b01, 2'b10));
        rd(1'b0, d); chk("R7 other flag cleared only", d[25:24], 64'h1);
        wr(1'b1, {32'hFFFF_FFFF, 32'h5});
        pulse(64'h10, 1);
        rd(1'b1, d); chk("R6 high wrap value", d, {32'h0, 32'h5});
        rd(1'b0, d); chk("R6 both flags", d[25:24], 64'h3);
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b01, 2'b01));
        rd(1'b0, d); chk("R7 low cleared", d[25:24], 64'h2);
        chk("R8 irq off when enable missing", {63'h0, irq}, 64'h0);
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b10, 2'b00));
        chk("R8 irq from high flag", {63'h0, irq}, 64'h1);
        wr(1'b0, mk_ctrl(6'd3, 6'd4, 3'b001, 2'b10, 2'b10));
        chk("R8 irq drops", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_nop();
        logic [63:0] d;
        ctx = 2'd0;
        wr(1'b0, mk_ctrl(6'd0, 6'd63, 3'b001, 2'b00, 2'b00));
        wr(1'b1, 64'h0);
        pulse(64'h1, 4);
        pulse(64'hFFFF_FFFF_FFFF_FFFE & ~(64'h1 << 63), 3);
        pulse(64'h1 << 63, 2);
        rd(1'b1, d); chk("R10 nop select", d, {32'd2, 32'd4});
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_ctx();
        t_write_pri();
        t_ovf();
        t_nop();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule